// File: doc/BRIEF.md
# Supply-Pulse Programming Sequence Decoder

This block turns a supply line that has been sampled into three levels (LOW, MID, HIGH) into programming commands. Each clock it reads a two-bit level code from external comparators. It ignores levels that do not last long enough. It measures how long each accepted pulse lasts and sorts it into one of three kinds: a mid pulse, a short high (framing) pulse, or a long high (blow) pulse.

A sequencer consumes these pulse events. A high pulse, a run of mid pulses and a second high pulse select a register key, and the block then enters Try mode. In Try mode each further mid pulse steps a 6-bit trial code. Nine mid pulses followed by a framing high switch to Blow mode, where mid pulses build a one-hot fuse address. A long high pulse then issues a single blow request.

Any protocol violation parks the block in a sticky error state. Only the power-on reset (`rst_n`), which stands for cycling the supply, clears it.

Top module: `prog_seq_decoder`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted pulse ends, every output is 0. Mode 0 means Try.
- R2: `lvl_i` encodes 0 = LOW, 1 = MID, 2 = HIGH, and 3 is treated as LOW. A level held for fewer than MIN_CYC (20) consecutive samples is ignored. A mid blip of 19 samples changes nothing, a mid pulse of exactly 20 samples counts, and a LOW dip shorter than MIN_CYC inside a high pulse does not split it.
- R3: From idle, a framing HIGH, then N MID pulses, then a framing HIGH selects key N when N is 0, 1 or 7. At that point `key_vld_o`=1, `key_o`=N, `try_code_o`=1 and `try_code_vld_o` pulses for one cycle.
- R4: In Try mode each MID pulse raises `try_code_o` by 1 and pulses `try_code_vld_o` for one cycle. The code saturates at 63, and the strobe still pulses at saturation.
- R5: In Try mode with key 0 or 7, if exactly nine MID pulses since selection are followed by a framing HIGH, `mode_blow_o` becomes 1, `blow_addr_o`=0 and `try_code_o`=0.
- R6: In Blow mode the n-th MID pulse (n = 1..6) sets `blow_addr_o` to the one-hot value with only bit n-1 set.
- R7: A HIGH held for BLOW_CYC (90) samples or more is a blow pulse, and one held for 20..89 samples is a framing pulse. A blow pulse in Blow mode with a nonzero address gives exactly one cycle of `blow_req_o`, and the address stays visible.
- R8: A key other than 0, 1 or 7 sets `err_o`. In the error state every other output reads 0, and `err_o` stays 1 through all later pulses until reset.
- R9: A framing error sets `err_o`. The framing errors are: a first pulse that is not a framing HIGH; a blow pulse before Blow mode; a Try-mode framing HIGH after a count other than nine; a seventh address pulse; a framing HIGH in Blow mode; a blow pulse with a zero address; and any pulse after a blow.
- R10: Asserting `rst_n` at any point clears the key, the mode, the code, the address and the error.
- R11: An attempt to enter Blow mode with key 1 sets `err_o`.
- R12: An accepted pulse changes the outputs at the clock edge MIN_CYC cycles after the first LOW sample that ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low power-on reset (supply cycle) |
| lvl_i | input | 2 | Comparator level code: 0 LOW, 1 MID, 2 HIGH |
| key_o | output | 3 | Selected register key |
| key_vld_o | output | 1 | A register key has been accepted |
| mode_blow_o | output | 1 | 0 Try mode, 1 Blow mode |
| try_code_o | output | 6 | Current Try-mode code |
| try_code_vld_o | output | 1 | One-cycle strobe on each new Try code |
| blow_addr_o | output | 6 | One-hot fuse address in Blow mode |
| blow_req_o | output | 1 | One-cycle blow request |
| err_o | output | 1 | Sticky protocol error |

## Verification
The assertions watch properties that hold on every cycle:
- the fuse address is never more than one-hot;
- a blow request lasts one cycle and only comes with a nonzero address in Blow mode;
- code strobes occur only in Try mode;
- an error never clears itself;
- a key acceptance always comes with code 1;
- Blow-mode entry always starts with a cleared address;
- pulse events come only out of a settled non-LOW level.

Some behaviour depends on whole pulse sequences, and only the bench scenarios show it: glitch rejection at the 19/20-sample boundary, the 89/90-sample split between framing and blow, code saturation, the rejection of keys and of out-of-order sequences, and the exact cycle at which each decision appears.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;

  localparam int CODE_W = 6;
  localparam int KEY_W  = 3;
  localparam int CNT_W  = 4;

  typedef enum logic [1:0] {
    LV_LOW  = 2'd0,
    LV_MID  = 2'd1,
    LV_HIGH = 2'd2,
    LV_RSVD = 2'd3
  } lvl_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY,
    ST_TRY,
    ST_BADDR,
    ST_DONE,
    ST_ERR
  } st_e;

  function automatic lvl_e lvl_norm(input logic [1:0] raw);
    lvl_e v;
    v = lvl_e'(raw);
    return (v == LV_RSVD) ? LV_LOW : v;
  endfunction

  function automatic logic [CODE_W-1:0] code_bump(input logic [CODE_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_bump(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  function automatic logic [CODE_W-1:0] onehot_of(input logic [CNT_W-1:0] n);
    logic [CODE_W-1:0] r;
    r = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (n == CNT_W'(i + 1)) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic key_ok_try(input logic [CNT_W-1:0] n);
    return (n == CNT_W'(0)) || (n == CNT_W'(1)) || (n == CNT_W'(7));
  endfunction

  function automatic logic key_ok_blow(input logic [CNT_W-1:0] n);
    return (n == CNT_W'(0)) || (n == CNT_W'(7));
  endfunction

endpackage

// File: rtl/pgm_level_filter.sv
module pgm_level_filter
  import pgm_seq_pkg::*;
#(
  parameter int MIN_CYC  = 20,
  parameter int BLOW_CYC = 90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl_i,
  output logic       ev_vld_o,
  output logic       ev_high_o,
  output logic       ev_long_o
);

  localparam int RUN_W = $clog2(MIN_CYC + 1);
  localparam int LEN_W = $clog2(BLOW_CYC + 1);

  lvl_e             raw;
  lvl_e             cand_q;
  lvl_e             stab_q;
  logic [RUN_W-1:0] run_q;
  logic [LEN_W-1:0] plen_q;

  // named internal events
  logic settle;
  logic stab_chg;
  logic plen_full;

  assign raw       = lvl_norm(lvl_i);
  assign settle    = (raw == cand_q) && (run_q == RUN_W'(MIN_CYC - 1));
  assign stab_chg  = settle && (cand_q != stab_q);
  assign plen_full = (plen_q == LEN_W'(BLOW_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q    <= LV_LOW;
      stab_q    <= LV_LOW;
      run_q     <= RUN_W'(MIN_CYC);
      plen_q    <= '0;
      ev_vld_o  <= 1'b0;
      ev_high_o <= 1'b0;
      ev_long_o <= 1'b0;
    end else begin
      if (raw != cand_q) begin
        cand_q <= raw;
        run_q  <= RUN_W'(1);
      end else if (run_q != RUN_W'(MIN_CYC)) begin
        run_q <= run_q + 1'b1;
      end

      if (stab_chg) begin
        stab_q <= cand_q;
        plen_q <= LEN_W'(1);
      end else if (!plen_full) begin
        plen_q <= plen_q + 1'b1;
      end

      ev_vld_o  <= stab_chg && (stab_q != LV_LOW);
      ev_high_o <= (stab_q == LV_HIGH);
      ev_long_o <= plen_full;
    end
  end

  // an event only ever closes a settled non-LOW level
  assert_event_from_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vld_o |-> ($past(stab_q) != LV_LOW));

  // a settled level never changes without a full qualifying run
  assert_stab_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stab_q != $past(stab_q)) |-> $past(settle));

endmodule

// File: rtl/pgm_seq_fsm.sv
module pgm_seq_fsm
  import pgm_seq_pkg::*;
#(
  parameter int BLOW_KEY_N = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_vld_i,
  input  logic              ev_high_i,
  input  logic              ev_long_i,
  output logic [KEY_W-1:0]  key_o,
  output logic              key_vld_o,
  output logic              mode_blow_o,
  output logic [CODE_W-1:0] code_o,
  output logic              code_vld_o,
  output logic [CODE_W-1:0] addr_o,
  output logic              blow_req_o,
  output logic              err_o
);

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;

  // decoded pulse kinds
  logic ev_mid;
  logic ev_frame;
  logic ev_blow;
  logic go_err;

  assign ev_mid   = ev_vld_i && !ev_high_i;
  assign ev_frame = ev_vld_i && ev_high_i && !ev_long_i;
  assign ev_blow  = ev_vld_i && ev_high_i && ev_long_i;

  always_comb begin
    go_err = 1'b0;
    unique case (st_q)
      ST_IDLE:  go_err = ev_vld_i && !ev_frame;
      ST_KEY:   go_err = ev_blow || (ev_frame && !key_ok_try(cnt_q));
      ST_TRY:   go_err = ev_blow ||
                         (ev_frame && !((cnt_q == CNT_W'(BLOW_KEY_N)) &&
                                        key_ok_blow(CNT_W'(key_o))));
      ST_BADDR: go_err = ev_frame ||
                         (ev_mid && (cnt_q >= CNT_W'(CODE_W))) ||
                         (ev_blow && (addr_o == '0));
      ST_DONE:  go_err = ev_vld_i;
      default:  go_err = 1'b0;
    endcase
  end

  assign err_o = (st_q == ST_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      key_o       <= '0;
      key_vld_o   <= 1'b0;
      mode_blow_o <= 1'b0;
      code_o      <= '0;
      code_vld_o  <= 1'b0;
      addr_o      <= '0;
      blow_req_o  <= 1'b0;
    end else begin
      code_vld_o <= 1'b0;
      blow_req_o <= 1'b0;
      if (go_err) begin
        st_q        <= ST_ERR;
        key_o       <= '0;
        key_vld_o   <= 1'b0;
        mode_blow_o <= 1'b0;
        code_o      <= '0;
        addr_o      <= '0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (ev_frame) begin
            st_q  <= ST_KEY;
            cnt_q <= '0;
          end
          ST_KEY: begin
            if (ev_mid) cnt_q <= cnt_bump(cnt_q);
            else if (ev_frame) begin
              st_q       <= ST_TRY;
              key_o      <= cnt_q[KEY_W-1:0];
              key_vld_o  <= 1'b1;
              code_o     <= CODE_W'(1);
              code_vld_o <= 1'b1;
              cnt_q      <= '0;
            end
          end
          ST_TRY: begin
            if (ev_mid) begin
              code_o     <= code_bump(code_o);
              code_vld_o <= 1'b1;
              cnt_q      <= cnt_bump(cnt_q);
            end else if (ev_frame) begin
              st_q        <= ST_BADDR;
              mode_blow_o <= 1'b1;
              code_o      <= '0;
              addr_o      <= '0;
              cnt_q       <= '0;
            end
          end
          ST_BADDR: begin
            if (ev_mid) begin
              cnt_q  <= cnt_q + 1'b1;
              addr_o <= onehot_of(cnt_q + 1'b1);
            end else if (ev_blow) begin
              blow_req_o <= 1'b1;
              st_q       <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_addr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_o));

  assert_single_blow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blow_req_o |=> !blow_req_o);

  assert_blow_has_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blow_req_o |-> (mode_blow_o && (addr_o != '0)));

  assert_code_strobe_try_R4: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld_o |-> (!mode_blow_o && (code_o != '0)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_select_code_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_vld_o) |-> (code_vld_o && (code_o == CODE_W'(1))));

  assert_blow_entry_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_blow_o) |-> ((addr_o == '0) && (code_o == '0)));

endmodule

// File: rtl/prog_seq_decoder.sv
module prog_seq_decoder
  import pgm_seq_pkg::*;
#(
  parameter int MIN_CYC    = 20,
  parameter int BLOW_CYC   = 90,
  parameter int BLOW_KEY_N = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lvl_i,
  output logic [KEY_W-1:0]  key_o,
  output logic              key_vld_o,
  output logic              mode_blow_o,
  output logic [CODE_W-1:0] try_code_o,
  output logic              try_code_vld_o,
  output logic [CODE_W-1:0] blow_addr_o,
  output logic              blow_req_o,
  output logic              err_o
);

  logic ev_vld;
  logic ev_high;
  logic ev_long;

  pgm_level_filter #(
    .MIN_CYC  (MIN_CYC),
    .BLOW_CYC (BLOW_CYC)
  ) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (lvl_i),
    .ev_vld_o  (ev_vld),
    .ev_high_o (ev_high),
    .ev_long_o (ev_long)
  );

  pgm_seq_fsm #(
    .BLOW_KEY_N (BLOW_KEY_N)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_vld_i    (ev_vld),
    .ev_high_i   (ev_high),
    .ev_long_i   (ev_long),
    .key_o       (key_o),
    .key_vld_o   (key_vld_o),
    .mode_blow_o (mode_blow_o),
    .code_o      (try_code_o),
    .code_vld_o  (try_code_vld_o),
    .addr_o      (blow_addr_o),
    .blow_req_o  (blow_req_o),
    .err_o       (err_o)
  );

  // no strobe of either kind fires while the block is in error
  assert_quiet_in_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !(try_code_vld_o || blow_req_o || key_vld_o));

endmodule

// File: tb/tb_prog_seq_decoder.sv
`timescale 1ns/1ps
module tb_prog_seq_decoder;

  localparam int MIN  = 20;
  localparam int BLOW = 90;
  localparam logic [1:0] LO = 2'd0;
  localparam logic [1:0] MD = 2'd1;
  localparam logic [1:0] HI = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lvl_i = LO;
  logic [2:0] key_o;
  logic       key_vld_o, mode_blow_o, try_code_vld_o, blow_req_o, err_o;
  logic [5:0] try_code_o, blow_addr_o;

  always #4 clk = ~clk;

  prog_seq_decoder #(.MIN_CYC(MIN), .BLOW_CYC(BLOW), .BLOW_KEY_N(9)) dut (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i),
    .key_o(key_o), .key_vld_o(key_vld_o), .mode_blow_o(mode_blow_o),
    .try_code_o(try_code_o), .try_code_vld_o(try_code_vld_o),
    .blow_addr_o(blow_addr_o), .blow_req_o(blow_req_o), .err_o(err_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_st, m_cnt, m_key, m_kv, m_mb, m_code, m_addr, m_cv, m_br, m_er;
  int cd = 0;
  int pend_hi = 0;
  int pend_w = 0;

  function automatic void m_reset();
    m_st = 0; m_cnt = 0; m_key = 0; m_kv = 0; m_mb = 0;
    m_code = 0; m_addr = 0; m_cv = 0; m_br = 0; m_er = 0;
    cd = 0;
  endfunction

  function automatic void m_fail();
    m_st = 5; m_key = 0; m_kv = 0; m_mb = 0; m_code = 0; m_addr = 0; m_er = 1;
  endfunction

  function automatic void m_apply(input int hi, input int w);
    bit mid, fr, bl;
    mid = (hi == 0);
    fr  = (hi != 0) && (w < BLOW);
    bl  = (hi != 0) && (w >= BLOW);
    case (m_st)
      0: if (fr) begin m_st = 1; m_cnt = 0; end else m_fail();
      1: if (mid) m_cnt = (m_cnt < 15) ? m_cnt + 1 : 15;
         else if (fr && (m_cnt == 0 || m_cnt == 1 || m_cnt == 7)) begin
           m_st = 2; m_key = m_cnt; m_kv = 1; m_code = 1; m_cv = 1; m_cnt = 0;
         end else m_fail();
      2: if (mid) begin
           m_code = (m_code < 63) ? m_code + 1 : 63; m_cv = 1;
           m_cnt = (m_cnt < 15) ? m_cnt + 1 : 15;
         end else if (fr && m_cnt == 9 && (m_key == 0 || m_key == 7)) begin
           m_st = 3; m_mb = 1; m_code = 0; m_addr = 0; m_cnt = 0;
         end else m_fail();
      3: if (mid) begin
           if (m_cnt < 6) begin m_cnt++; m_addr = 1 << (m_cnt - 1); end
           else m_fail();
         end else if (bl && m_addr != 0) begin m_br = 1; m_st = 4; end
         else m_fail();
      4: m_fail();
      default: ;
    endcase
  endfunction

  task automatic step();
    logic [21:0] act, exp;
    @(posedge clk);
    @(negedge clk);
    m_cv = 0; m_br = 0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) m_apply(pend_hi, pend_w);
    end
    act = {key_vld_o, key_o, mode_blow_o, try_code_o, try_code_vld_o,
           blow_addr_o, blow_req_o, err_o};
    exp = {m_kv[0], m_key[2:0], m_mb[0], m_code[5:0], m_cv[0],
           m_addr[5:0], m_br[0], m_er[0]};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b (kv key mb code cv addr br er)",
               cur_req, $time, act, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] lv, input int w, input int gap = 30);
    lvl_i = lv;
    repeat (w) step();
    lvl_i = LO;
    if (w >= MIN) begin cd = MIN + 1; pend_hi = (lv == HI); pend_w = w; end
    repeat (gap) step();
  endtask

  task automatic hi_dip(input int a, input int d, input int b);
    lvl_i = HI; repeat (a) step();
    lvl_i = LO; repeat (d) step();
    lvl_i = HI; repeat (b) step();
    lvl_i = LO;
    cd = MIN + 1; pend_hi = 1; pend_w = a + d + b;
    repeat (30) step();
  endtask

  task automatic do_reset();
    lvl_i = LO;
    rst_n = 1'b0;
    m_reset();
    repeat (3) step();
    rst_n = 1'b1;
    repeat (5) step();
  endtask

  task automatic select_key(input int n, input int open_w = 25);
    pulse(HI, open_w);
    for (int i = 0; i < n; i++) pulse(MD, 25);
    pulse(HI, 25);
  endtask

  task automatic mids(input int n);
    for (int i = 0; i < n; i++) pulse(MD, 25);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state and idle after release
    cur_req = "R1";
    do_reset();
    repeat (10) step();

    // R12: first key selection, decision timing; R3 key 0
    cur_req = "R12";
    select_key(0);
    cur_req = "R4";
    mids(3);
    // R2: 19-sample mid ignored, 20-sample mid counts
    cur_req = "R2";
    pulse(MD, 5);
    pulse(MD, MIN - 1);
    pulse(MD, MIN);

    // R10: reset clears key, mode and code
    cur_req = "R10";
    do_reset();
    repeat (5) step();

    // R3 with an 89-sample opening high (framing, R7 boundary)
    cur_req = "R3";
    select_key(7, BLOW - 1);
    // R5: nine mids then framing high enters Blow mode
    cur_req = "R5";
    mids(9);
    pulse(HI, 25);
    // R6: three address pulses -> bit 2
    cur_req = "R6";
    mids(3);
    // R7: blow pulse with a short low dip inside (R2 glitch)
    cur_req = "R7";
    hi_dip(50, 5, 50);
    // R9: any pulse after a blow
    cur_req = "R9";
    pulse(MD, 25);

    // R7: exact 90-sample blow with address bit 5, R6 full range
    cur_req = "R6";
    do_reset();
    select_key(0);
    mids(9);
    pulse(HI, 25);
    mids(6);
    cur_req = "R7";
    pulse(HI, BLOW);

    // R4: saturation at 63
    cur_req = "R4";
    do_reset();
    select_key(1);
    mids(65);

    // R11: Blow entry with key 1
    cur_req = "R11";
    do_reset();
    select_key(1);
    mids(9);
    pulse(HI, 25);

    // R8: unrecognised key, sticky error
    cur_req = "R8";
    do_reset();
    select_key(3);
    mids(2);
    pulse(HI, 25);
    cur_req = "R8";
    do_reset();
    select_key(8);

    // R9: framing violations
    cur_req = "R9";
    do_reset();
    pulse(MD, 25);
    do_reset();
    pulse(HI, BLOW + 5);
    do_reset();
    select_key(0);
    mids(4);
    pulse(HI, 25);
    do_reset();
    select_key(0);
    mids(9);
    pulse(HI, 25);
    mids(7);
    do_reset();
    select_key(7);
    mids(9);
    pulse(HI, 25);
    pulse(HI, BLOW + 10);
    do_reset();
    select_key(0);
    mids(9);
    pulse(HI, 25);
    mids(1);
    pulse(HI, 25);

    cur_req = "R1";
    do_reset();
    repeat (5) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule